// File: doc/BRIEF.md
# GPU Command Packet Framer

The framer sits between a 32-bit command word stream and a drawing engine. It takes words one at a time over a valid/ready handshake and groups them into whole command packets. The top byte of the first word of each packet is the opcode. The opcode fixes the number of words that follow, or, for the two polyline families, says that the packet runs until a terminator word arrives. A packet is buffered until its last word has arrived. It is then sent downstream one word per cycle, with first and last markers, the opcode and the total word count. Input is stalled while a packet is being sent.

Three opcode groups need extra handling:
- An image-upload command is emitted as a three-word packet. The words that follow it bypass packet framing and leave on a pixel side channel, one word for every two 16-bit pixels of the rectangle.
- The eight environment opcodes also store their whole word in a register bank. The renderer reads this bank through an index port.
- A status vector mirrors selected environment fields.

A polyline that would exceed the buffer is dropped and raises a sticky error.

Top module: `pf_framer`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word. A fixed-length packet is emitted with `pkt_len` = 1 + the opcode's parameter count:
  - 0x02: 2 parameters.
  - 0x20-0x3F: indexed by opcode bits 4:2, the counts are 3,6,4,8,5,8,7,11.
  - 0x40-0x47: 2. 0x50-0x57: 4.
  - 0x60-0x7F: indexed by opcode bits 4:2, the counts are 2,3,1,0,1,2,1,2.
  - 0x80-0x9F: 3. 0xA0-0xDF: 2.
  - Every other opcode: 0.
- R2: No word of a packet appears on the output until all of its words have been accepted. The words then appear in arrival order on consecutive cycles. `pkt_first` marks the first word and `pkt_last` marks the last. `in_ready` is low while `pkt_valid` is high.
- R3: A flat polyline (opcode 0x48-0x4F) ends at the first word with index 3 or higher (first word = index 0) whose value ANDed with 0xF000F000 equals 0x50005000. That word is included in the packet.
- R4: A shaded polyline (opcode 0x58-0x5F) uses the same terminator test, but only on even word indices of 4 or higher. Matching words at odd indices do not end the packet.
- R5: After an image-upload packet (opcode 0xA0-0xBF, three words), the next ceil(w*h/2) accepted words go out on `pix_valid`/`pix_data` and produce no packet. Here w = ((size[9:0]-1) mod 1024)+1 and h = ((size[24:16]-1) mod 512)+1, with size being the third word. Command framing then resumes.
- R6: Image-download opcodes 0xC0-0xDF form three-word packets and do not enter pixel mode. Copy opcodes 0x80-0x9F form four-word packets.
- R7: Opcodes 0xE0-0xE7 store their whole word into environment register (opcode AND 7). `env_word` shows register `env_idx`. Opcodes 0xE8-0xFF change no register.
- R8: `status[10:0]` equals bits 10:0 of environment register 1, and `status[12:11]` equals bits 1:0 of environment register 6.
- R9: After reset, environment register i holds (0xE0+i) in bits 31:24 and zero elsewhere. `status` and `err_ovf` are 0, `pkt_valid` is low and `in_ready` is high.
- R10: A polyline that reaches DEPTH words without a terminator is discarded with nothing emitted, and `err_ovf` is set and stays set. The next word starts a new packet. No other stream sets `err_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Framer can take a word |
| in_data | input | 32 | Command word |
| pkt_valid | output | 1 | Packet word on output |
| pkt_first | output | 1 | First word of packet |
| pkt_last | output | 1 | Last word of packet |
| pkt_opcode | output | 8 | Opcode of current packet |
| pkt_len | output | $clog2(DEPTH+1) | Word count of current packet |
| pkt_data | output | 32 | Packet word |
| pix_valid | output | 1 | Pixel word accepted this cycle |
| pix_data | output | 32 | Pixel word (two pixels) |
| env_idx | input | 3 | Environment register select |
| env_word | output | 32 | Selected environment register |
| status | output | 13 | Mirrored environment fields |
| err_ovf | output | 1 | Sticky polyline overflow flag |

## Verification
A table sweeps one opcode from each length class, including both ends of several ranges. This separates each decoded count from its neighbours, and it also separates download and copy packets from uploads. Two polyline streams contain terminator-shaped words at positions that must not end the packet: before index 3, and at odd shaded indices. A wrong scan start or a wrong stride therefore shows up as a shorter packet. Image uploads with an even and an odd pixel total check the rounding and the return to command framing. A stalled partial packet, environment writes next to a non-storing opcode, and a runaway polyline cover holding, latching and overflow.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
package pf_pkg;

  localparam int ENV_N = 8;
  localparam int PIX_W = 20;

  typedef enum logic [1:0] {K_FIXED, K_FLAT, K_SHADE} kind_e;
  typedef enum logic [1:0] {ST_COLLECT, ST_EMIT, ST_PIX} fr_state_e;

  // Parameter words that follow the opcode word (fixed-length opcodes).
  function automatic logic [3:0] param_count(input logic [7:0] op);
    logic [3:0] n;
    n = 4'd0;
    unique case (op[7:5])
      3'b000: n = (op == 8'h02) ? 4'd2 : 4'd0;
      3'b001: begin
        unique case (op[4:2])
          3'd0: n = 4'd3;
          3'd1: n = 4'd6;
          3'd2: n = 4'd4;
          3'd3: n = 4'd8;
          3'd4: n = 4'd5;
          3'd5: n = 4'd8;
          3'd6: n = 4'd7;
          default: n = 4'd11;
        endcase
      end
      3'b010: begin
        unique case (op[4:3])
          2'd0: n = 4'd2;
          2'd1: n = 4'd3;
          default: n = 4'd4;
        endcase
      end
      3'b011: begin
        unique case (op[4:2])
          3'd0: n = 4'd2;
          3'd1: n = 4'd3;
          3'd2: n = 4'd1;
          3'd3: n = 4'd0;
          3'd4: n = 4'd1;
          3'd5: n = 4'd2;
          3'd6: n = 4'd1;
          default: n = 4'd2;
        endcase
      end
      3'b100: n = 4'd3;
      3'b101, 3'b110: n = 4'd2;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

  function automatic logic is_poly_end(input logic [31:0] w);
    return (w & 32'hF000_F000) == 32'h5000_5000;
  endfunction

  // Words carrying a w x h rectangle of 16-bit pixels, two per word.
  function automatic logic [PIX_W-1:0] pix_words(input logic [31:0] size);
    logic [9:0]  wm1;
    logic [8:0]  hm1;
    logic [20:0] prod;
    wm1  = size[9:0] - 10'd1;
    hm1  = size[24:16] - 9'd1;
    prod = 21'({1'b0, wm1} + 11'd1) * 21'({1'b0, hm1} + 10'd1);
    return PIX_W'((prod + 21'd1) >> 1);
  endfunction

endpackage

// File: rtl/pf_op_decode.sv
`timescale 1ns/1ps
module pf_op_decode (
  input  logic [7:0]     op,
  output pf_pkg::kind_e  kind,
  output logic [3:0]     fixed_len,
  output logic           is_img_wr,
  output logic           is_env_wr
);
  import pf_pkg::*;

  always_comb begin
    if (op[7:3] == 5'b01001)      kind = K_FLAT;
    else if (op[7:3] == 5'b01011) kind = K_SHADE;
    else                          kind = K_FIXED;
  end

  assign fixed_len = param_count(op) + 4'd1;
  assign is_img_wr = (op[7:5] == 3'b101);
  assign is_env_wr = (op[7:3] == 5'b11100);

endmodule

// File: rtl/pf_word_store.sv
`timescale 1ns/1ps
module pf_word_store #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pf_env_bank.sv
`timescale 1ns/1ps
module pf_env_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_idx,
  output logic [31:0] rd_data,
  output logic [12:0] status
);
  import pf_pkg::*;

  logic [31:0] env_q [ENV_N];

  generate
    for (genvar g = 0; g < ENV_N; g++) begin : g_env
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             env_q[g] <= {8'hE0 + 8'(g), 24'h0};
        else if (wr_en && wr_idx == 3'(g))      env_q[g] <= wr_data;
      end
    end
  endgenerate

  assign rd_data = env_q[rd_idx];
  assign status  = {env_q[6][1:0], env_q[1][10:0]};

  // R7: a store is visible in the addressed register on the next cycle
  a_r7_env_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> env_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/pf_framer.sv
`timescale 1ns/1ps
module pf_framer #(
  parameter int DEPTH = 16,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  output logic             pkt_valid,
  output logic             pkt_first,
  output logic             pkt_last,
  output logic [7:0]       pkt_opcode,
  output logic [LEN_W-1:0] pkt_len,
  output logic [31:0]      pkt_data,
  output logic             pix_valid,
  output logic [31:0]      pix_data,
  input  logic [2:0]       env_idx,
  output logic [31:0]      env_word,
  output logic [12:0]      status,
  output logic             err_ovf
);
  import pf_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);

  fr_state_e        st_q;
  logic [IDX_W-1:0] cnt_q, rd_q;
  logic [7:0]       op_q;
  logic [LEN_W-1:0] len_q;
  logic             img_q, err_q;
  logic [PIX_W-1:0] pix_rem_q;

  // Decode of the opcode that governs the word now at the input.
  logic [7:0]  cur_op;
  kind_e       kind;
  logic [3:0]  fixed_len;
  logic        is_img_wr, is_env_wr;

  assign cur_op = (cnt_q == '0) ? in_data[31:24] : op_q;

  pf_op_decode u_dec (
    .op        (cur_op),
    .kind      (kind),
    .fixed_len (fixed_len),
    .is_img_wr (is_img_wr),
    .is_env_wr (is_env_wr)
  );

  // Named events
  logic             accept, collect_acc, pkt_end, done_evt, ovf_evt, emit_end;
  logic [LEN_W-1:0] idx_p1;
  logic             term_hit;

  assign accept      = in_valid && in_ready;
  assign collect_acc = accept && (st_q == ST_COLLECT);
  assign idx_p1      = LEN_W'(cnt_q) + LEN_W'(1);
  assign term_hit    = is_poly_end(in_data);

  always_comb begin
    pkt_end = 1'b0;
    unique case (kind)
      K_FIXED: pkt_end = (idx_p1 == LEN_W'(fixed_len));
      K_FLAT:  pkt_end = (cnt_q >= IDX_W'(3)) && term_hit;
      K_SHADE: pkt_end = (cnt_q >= IDX_W'(4)) && !cnt_q[0] && term_hit;
      default: pkt_end = 1'b0;
    endcase
  end

  assign done_evt = collect_acc && pkt_end;
  assign ovf_evt  = collect_acc && !pkt_end && (cnt_q == IDX_W'(DEPTH - 1));
  assign emit_end = (st_q == ST_EMIT) && (LEN_W'(rd_q) + LEN_W'(1) == len_q);

  // Packet word buffer
  pf_word_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (collect_acc),
    .waddr (cnt_q),
    .wdata (in_data),
    .raddr (rd_q),
    .rdata (pkt_data)
  );

  // Environment registers and status mirror
  pf_env_bank u_env (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (done_evt && is_env_wr),
    .wr_idx  (cur_op[2:0]),
    .wr_data (in_data),
    .rd_idx  (env_idx),
    .rd_data (env_word),
    .status  (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_COLLECT;
      cnt_q     <= '0;
      rd_q      <= '0;
      op_q      <= '0;
      len_q     <= '0;
      img_q     <= 1'b0;
      err_q     <= 1'b0;
      pix_rem_q <= '0;
    end else begin
      unique case (st_q)
        ST_COLLECT: begin
          if (collect_acc) begin
            if (cnt_q == '0) op_q <= in_data[31:24];
            if (done_evt) begin
              cnt_q <= '0;
              len_q <= idx_p1;
              rd_q  <= '0;
              img_q <= is_img_wr;
              if (is_img_wr) pix_rem_q <= pix_words(in_data);
              st_q  <= ST_EMIT;
            end else if (ovf_evt) begin
              cnt_q <= '0;
              err_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + IDX_W'(1);
            end
          end
        end
        ST_EMIT: begin
          rd_q <= rd_q + IDX_W'(1);
          if (emit_end) st_q <= img_q ? ST_PIX : ST_COLLECT;
        end
        ST_PIX: begin
          if (accept) begin
            pix_rem_q <= pix_rem_q - PIX_W'(1);
            if (pix_rem_q == PIX_W'(1)) st_q <= ST_COLLECT;
          end
        end
        default: st_q <= ST_COLLECT;
      endcase
    end
  end

  assign in_ready   = (st_q != ST_EMIT);
  assign pkt_valid  = (st_q == ST_EMIT);
  assign pkt_first  = pkt_valid && (rd_q == '0);
  assign pkt_last   = emit_end;
  assign pkt_opcode = op_q;
  assign pkt_len    = len_q;
  assign pix_valid  = (st_q == ST_PIX) && in_valid;
  assign pix_data   = in_data;
  assign err_ovf    = err_q;

  // R2: no word is taken while a packet is leaving
  a_r2_stall_on_emit: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !in_ready);

  // R2: packet words leave on consecutive cycles until the last one
  a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_last) |=> (pkt_valid && !pkt_first));

  // R1: emitted length stays within the buffer
  a_r1_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len != '0 && pkt_len <= LEN_W'(DEPTH)));

  // R5: pixel words and packet words never share a cycle
  a_r5_pix_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !pkt_valid);

  // R5: pixel mode always has words left to take
  a_r5_pix_remaining: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PIX) |-> (pix_rem_q != '0));

  // R10: overflow flag is sticky
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |=> err_ovf);

  // R10: an overflow emits nothing and flags the error
  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (!pkt_valid && err_ovf));

endmodule

// File: tb/sim_pf_framer.sv
`timescale 1ns/1ps
module sim_pf_framer;

  localparam int DEPTH = 16;
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [31:0]      in_data = '0;
  logic             pkt_valid, pkt_first, pkt_last;
  logic [7:0]       pkt_opcode;
  logic [LEN_W-1:0] pkt_len;
  logic [31:0]      pkt_data;
  logic             pix_valid;
  logic [31:0]      pix_data;
  logic [2:0]       env_idx = '0;
  logic [31:0]      env_word;
  logic [12:0]      status;
  logic             err_ovf;

  always #2 clk = ~clk;

  pf_framer #(.DEPTH(DEPTH)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Output monitor: samples 1 ns after the falling edge
  logic [31:0] got [32];
  int          wn = 0, pkt_n = 0, got_len = 0, proto_bad = 0, pix_n = 0;
  logic [7:0]  got_op;
  logic [31:0] pix_last;

  always begin
    @(negedge clk);
    #1;
    if (pkt_valid) begin
      if (pkt_first) wn = 0;
      else if (wn == 0) proto_bad++;
      if (wn < 32) got[wn] = pkt_data;
      wn++;
      if (pkt_last) begin
        pkt_n++;
        got_op  = pkt_opcode;
        got_len = int'(pkt_len);
        if (got_len != wn) proto_bad++;
        wn = 0;
      end
    end
    if (pix_valid) begin
      pix_n++;
      pix_last = pix_data;
    end
  end

  // Stimulus helpers (called at a falling edge)
  logic [31:0] sent [32];
  int          sn = 0;

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (sn < 32) sent[sn] = w;
    sn++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit words_match(input int n);
    for (int i = 0; i < n; i++) if (got[i] !== sent[i]) return 0;
    return 1;
  endfunction

  // {opcode, expected total words}
  localparam int NV = 30;
  localparam bit [15:0] VEC [NV] = '{
    16'h02_03, 16'h00_01, 16'h01_01, 16'h1F_01, 16'h20_04, 16'h24_07,
    16'h28_05, 16'h2C_09, 16'h2E_09, 16'h30_06, 16'h34_09, 16'h38_08,
    16'h3C_0C, 16'h40_03, 16'h50_05, 16'h60_03, 16'h64_04, 16'h68_02,
    16'h6C_01, 16'h6F_01, 16'h70_02, 16'h74_03, 16'h78_02, 16'h7C_03,
    16'h80_04, 16'h9F_04, 16'hC0_03, 16'hDF_03, 16'hE8_01, 16'hFF_01
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base, pbase;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R9: reset state
    chk("R9 pkt_valid", {31'h0, pkt_valid}, 32'h0);
    chk("R9 in_ready", {31'h0, in_ready}, 32'h1);
    chk("R9 status", {19'h0, status}, 32'h0);
    chk("R9 err_ovf", {31'h0, err_ovf}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      env_idx = 3'(i);
      #1;
      chk("R9 env reset", env_word, {8'hE0 + 8'(i), 24'h0});
    end
    @(negedge clk);

    // R1/R6: opcode length table
    for (int v = 0; v < NV; v++) begin
      int len;
      len  = int'(VEC[v][7:0]);
      base = pkt_n;
      sn   = 0;
      send({VEC[v][15:8], 24'h000100 + 24'(v)});
      for (int k = 1; k < len; k++) send(32'h0001_0002 + 32'(k));
      idle(len + 4);
      chk($sformatf("R1 count op%02h", VEC[v][15:8]), pkt_n, base + 1);
      chk($sformatf("R1 opcode op%02h", VEC[v][15:8]), {24'h0, got_op}, {24'h0, VEC[v][15:8]});
      chk($sformatf("R1 len op%02h", VEC[v][15:8]), got_len, len);
      chk($sformatf("R2 order op%02h", VEC[v][15:8]), {31'h0, words_match(len)}, 32'h1);
    end
    // R6: no pixel words after downloads and copies
    chk("R6 no pixels", pix_n, 0);

    // R2: partial packet is held
    base = pkt_n;
    sn = 0;
    send(32'h2C00_0000);
    send(32'h0000_0011);
    send(32'h0000_0022);
    idle(10);
    chk("R2 hold partial", pkt_n, base);
    for (int k = 3; k < 9; k++) send(32'h0000_0100 + 32'(k));
    idle(12);
    chk("R2 completed", pkt_n, base + 1);
    chk("R2 len", got_len, 9);
    chk("R2 order", {31'h0, words_match(9)}, 32'h1);
    chk("R2 protocol", proto_bad, 0);

    // R3: flat polyline, terminator-like words before index 3 ignored
    base = pkt_n;
    sn = 0;
    send(32'h4800_0000);
    send(32'h5000_5000);
    send(32'h5500_5500);
    send(32'h0001_0002);
    send(32'h5ABC_5DEF);
    idle(10);
    chk("R3 count", pkt_n, base + 1);
    chk("R3 len", got_len, 5);
    chk("R3 order", {31'h0, words_match(5)}, 32'h1);

    // R4: shaded polyline, odd-index terminator ignored
    base = pkt_n;
    send(32'h5800_0000);
    send(32'h0000_0001);
    send(32'h5000_5000);
    send(32'h5000_5000);
    send(32'h0000_0004);
    send(32'h5FFF_5FFF);
    send(32'h5123_5456);
    idle(12);
    chk("R4 count", pkt_n, base + 1);
    chk("R4 len", got_len, 7);
    chk("R4 opcode", {24'h0, got_op}, 32'h58);

    // R5: upload 3x2 -> 3 pixel words
    base = pkt_n;
    pbase = pix_n;
    send(32'hA000_0000);
    send(32'h0000_0000);
    send(32'h0002_0003);
    send(32'h1111_1111);
    send(32'h2222_2222);
    send(32'h3333_3333);
    idle(3);
    chk("R5 packet count", pkt_n, base + 1);
    chk("R5 packet len", got_len, 3);
    chk("R5 pixel words", pix_n, pbase + 3);
    chk("R5 last pixel", pix_last, 32'h3333_3333);
    send(32'h6C00_0000);
    idle(4);
    chk("R5 resume", pkt_n, base + 2);
    chk("R5 resume op", {24'h0, got_op}, 32'h6C);
    chk("R5 no extra pixel", pix_n, pbase + 3);

    // R5: upload 3x1 -> 2 pixel words (odd pixel total)
    base = pkt_n;
    pbase = pix_n;
    send(32'hBF00_0000);
    send(32'h0010_0010);
    send(32'h0001_0003);
    send(32'hAAAA_0001);
    send(32'hBBBB_0002);
    send(32'h6C00_0000);
    idle(4);
    chk("R5 odd pixels", pix_n, pbase + 2);
    chk("R5 odd resume", pkt_n, base + 2);
    chk("R5 odd resume op", {24'h0, got_op}, 32'h6C);

    // R7/R8: environment stores and status
    send(32'hE100_0345);
    send(32'hE600_0003);
    send(32'hE300_ABCD);
    send(32'hE900_0777);
    idle(6);
    env_idx = 3'd1;
    #1;
    chk("R7 env1", env_word, 32'hE100_0345);
    env_idx = 3'd3;
    #1;
    chk("R7 env3", env_word, 32'hE300_ABCD);
    env_idx = 3'd6;
    #1;
    chk("R7 env6", env_word, 32'hE600_0003);
    env_idx = 3'd7;
    #1;
    chk("R7 E9 no store", env_word, 32'hE700_0000);
    chk("R8 status", {19'h0, status}, {19'h0, 2'b11, 11'h345});
    @(negedge clk);
    send(32'hE100_0400);
    idle(4);
    chk("R8 status update", {19'h0, status}, {19'h0, 2'b11, 11'h400});
    chk("R10 no false error", {31'h0, err_ovf}, 32'h0);

    // R10: runaway polyline
    base = pkt_n;
    send(32'h4800_0000);
    for (int k = 1; k < DEPTH; k++) send(32'h0001_0001);
    idle(4);
    chk("R10 nothing emitted", pkt_n, base);
    chk("R10 error set", {31'h0, err_ovf}, 32'h1);
    send(32'h6C00_0000);
    idle(4);
    chk("R10 restart", pkt_n, base + 1);
    chk("R10 restart op", {24'h0, got_op}, 32'h6C);
    chk("R10 sticky", {31'h0, err_ovf}, 32'h1);
    chk("R2 protocol end", proto_bad, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule